// File: doc/BRIEF.md
# Lazy Transactional Memory Controller

This block is a shared-memory controller for a small group of clients. Each client may read and write memory directly, or open a transaction. Inside a transaction, reads and writes are logged in a private buffer for that client. Writes in the buffer do not reach shared memory until the transaction commits. A commit succeeds only if no other client has already made the transaction stale. When it succeeds, the logged writes land in memory together.

Conflicts are found lazily. When a commit succeeds, or a direct write is made, every other open transaction whose log holds a read of a written address is marked doomed. A doomed transaction may keep reading and writing. Its commit is refused with an error, and the client is then expected to abort, which clears the doomed mark.

All requests arrive on one port, at most one per cycle. Each request is answered on the next cycle with one of three codes: acknowledge, error, or data together with a read value.

Top module: `tm_lazy_ctrl`

## Requirements
- R1: After reset all memory words read as zero, no client has an open transaction (a commit is answered with error), and no response is signalled until a request arrives.
- R2: Every request accepted with req_valid high at a clock edge gets resp_valid high, with a code other than idle, after exactly that edge. A cycle without a request gives resp_valid low and code idle (0). resp_rdata is zero unless the code is data. The codes are idle 0, acknowledge 1, error 2, data 3.
- R3: An open request (opcode 0) is acknowledged when the client has no open transaction. It is answered with error when one is already open.
- R4: A transactional read (opcode 1) from a client with an open transaction returns code data with the current memory word at req_addr, and logs the read. Any transactional access or commit from a client with no open transaction is answered with error.
- R5: A transactional write (opcode 2) is acknowledged and logged, and leaves shared memory unchanged while the transaction stays open.
- R6: A commit (opcode 3) from an open client that is not doomed is acknowledged. It writes every logged write to memory, with the later entry winning for a repeated address, and closes the transaction.
- R7: A successful commit dooms every other open client whose log holds a read of an address the commit wrote. A commit from a doomed client is answered with error and changes no state: the transaction stays open and doomed.
- R8: A direct read (opcode 5) or direct write (opcode 6) is answered with error while the client has an open transaction. Otherwise the read returns data from memory. The write updates memory at once, is acknowledged, and dooms every open client whose log holds a read of that address.
- R9: Each client's log holds 4 entries. A transactional read or write when the log is full is answered with error and is not logged. The logged accesses still commit normally.
- R10: An abort (opcode 4) from an open client is acknowledged. It discards the log without touching memory and clears the doomed mark. An abort with no open transaction is answered with error.
- R11: Opcode 7 is answered with error and changes nothing.
- R12: A doomed client's transactional reads and writes are still served: a read returns the current memory value and a write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cid | input | 2 | Requesting client number |
| req_op | input | 3 | Request opcode |
| req_addr | input | 4 | Word address |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | Response present, one cycle after its request |
| resp_code | output | 2 | Response code: idle, acknowledge, error or data |
| resp_rdata | output | 8 | Read value for code data, otherwise zero |

## Verification
A successful commit does three things in a single cycle: it copies the committing log into memory, it checks every other client's read log against that write set, and it sets their doomed marks. A direct write likewise updates a word and dooms the readers of that word in the same cycle. The bench provokes both cases by having one client read an address inside an open transaction while another client commits a write to that address or writes it directly. It then judges the outcome at the ports. The next direct read must return the new value. The victim's further reads must still be served. Its commit must be refused until it aborts. A constrained-random phase on only four addresses makes such overlaps frequent, and every response is compared with a behavioural model on each clock.

// File: rtl/tm_pkg.sv
`timescale 1ns/1ps
package tm_pkg;
    parameter int NCLIENT = 4;
    parameter int AW      = 4;
    parameter int DW      = 8;
    parameter int DEPTH   = 4;

    localparam int CIDW  = (NCLIENT > 1) ? $clog2(NCLIENT) : 1;
    localparam int NWORD = 1 << AW;
    localparam int CNTW  = $clog2(DEPTH + 1);

    typedef enum logic [2:0] {
        OP_BEGIN  = 3'd0,
        OP_TREAD  = 3'd1,
        OP_TWRITE = 3'd2,
        OP_COMMIT = 3'd3,
        OP_ABORT  = 3'd4,
        OP_NREAD  = 3'd5,
        OP_NWRITE = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_ERR  = 2'd2,
        RSP_DATA = 2'd3
    } rsp_e;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ent_t;

    typedef ent_t [DEPTH-1:0] buf_t;

    function automatic logic [NWORD-1:0] addr_mask(input logic [AW-1:0] a);
        return NWORD'(1) << a;
    endfunction

    function automatic logic [NWORD-1:0] write_set(input buf_t b);
        logic [NWORD-1:0] m;
        m = '0;
        for (int i = 0; i < DEPTH; i++)
            if (b[i].vld && b[i].wr) m[b[i].addr] = 1'b1;
        return m;
    endfunction

    function automatic logic [NWORD-1:0] read_set(input buf_t b);
        logic [NWORD-1:0] m;
        m = '0;
        for (int i = 0; i < DEPTH; i++)
            if (b[i].vld && !b[i].wr) m[b[i].addr] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tm_txn_buf.sv
`timescale 1ns/1ps
module tm_txn_buf
    import tm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic close_i,
    input  logic push_i,
    input  ent_t push_ent_i,
    input  logic doom_set_i,
    input  logic doom_clr_i,
    output logic is_open_o,
    output logic doomed_o,
    output logic full_o,
    output buf_t ents_o
);
    logic            open_q;
    logic            doom_q;
    logic [CNTW-1:0] cnt_q;
    ent_t            ents_q [DEPTH];

    assign full_o    = (cnt_q == CNTW'(DEPTH));
    assign is_open_o = open_q;
    assign doomed_o  = doom_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (open_i) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
        end else if (close_i) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (push_i && !full_o) begin
            cnt_q  <= cnt_q + CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || doom_clr_i) doom_q <= 1'b0;
        else if (doom_set_i)   doom_q <= 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || open_i || close_i)
                ents_q[i] <= '0;
            else if (push_i && cnt_q == CNTW'(i))
                ents_q[i] <= push_ent_i;
        end
        assign ents_o[i] = ents_q[i];
    end
endmodule

// File: rtl/tm_conflict.sv
`timescale 1ns/1ps
module tm_conflict
    import tm_pkg::*;
(
    input  logic               en_i,
    input  logic [CIDW-1:0]    src_i,
    input  logic [NWORD-1:0]   wmask_i,
    input  logic [NCLIENT-1:0] open_i,
    input  buf_t               bufs_i [NCLIENT],
    output logic [NCLIENT-1:0] hit_o
);
    for (genvar k = 0; k < NCLIENT; k++) begin : g_cl
        logic [NWORD-1:0] rs;
        assign rs       = read_set(bufs_i[k]);
        assign hit_o[k] = en_i && open_i[k] && (src_i != CIDW'(k)) && |(rs & wmask_i);
    end
endmodule

// File: rtl/tm_shared_mem.sv
`timescale 1ns/1ps
module tm_shared_mem
    import tm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_en_i,
    input  buf_t          commit_buf_i,
    input  logic          nt_en_i,
    input  logic [AW-1:0] nt_addr_i,
    input  logic [DW-1:0] nt_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);
    logic [DW-1:0] mem_q [NWORD];

    assign rd_data_o = mem_q[rd_addr_i];

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[w] <= '0;
            end else begin
                if (commit_en_i) begin
                    for (int i = 0; i < DEPTH; i++)
                        if (commit_buf_i[i].vld && commit_buf_i[i].wr &&
                            commit_buf_i[i].addr == AW'(w))
                            mem_q[w] <= commit_buf_i[i].data;
                end
                if (nt_en_i && nt_addr_i == AW'(w))
                    mem_q[w] <= nt_data_i;
            end
        end
    end
endmodule

// File: rtl/tm_lazy_ctrl.sv
`timescale 1ns/1ps
module tm_lazy_ctrl
    import tm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [CIDW-1:0] req_cid,
    input  logic [2:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            resp_valid,
    output logic [1:0]      resp_code,
    output logic [DW-1:0]   resp_rdata
);
    op_e                op;
    logic [NCLIENT-1:0] open_vec;
    logic [NCLIENT-1:0] doom_vec;
    logic [NCLIENT-1:0] full_vec;
    logic [NCLIENT-1:0] hit_vec;
    buf_t               bufs [NCLIENT];
    logic [DW-1:0]      mem_rd;
    logic [NWORD-1:0]   wmask;
    ent_t               push_ent;

    logic cid_ok, cur_open, cur_doom, cur_full;
    logic ok, is_data, do_open, do_push, do_commit, do_abort, do_nwr;

    assign op       = op_e'(req_op);
    assign cid_ok   = int'(req_cid) < NCLIENT;
    assign cur_open = cid_ok && open_vec[req_cid];
    assign cur_doom = cid_ok && doom_vec[req_cid];
    assign cur_full = cid_ok && full_vec[req_cid];

    always_comb begin
        ok        = 1'b0;
        is_data   = 1'b0;
        do_open   = 1'b0;
        do_push   = 1'b0;
        do_commit = 1'b0;
        do_abort  = 1'b0;
        do_nwr    = 1'b0;
        if (req_valid && cid_ok) begin
            case (op)
                OP_BEGIN:  if (!cur_open) begin ok = 1'b1; do_open = 1'b1; end
                OP_TREAD:  if (cur_open && !cur_full) begin
                               ok = 1'b1; is_data = 1'b1; do_push = 1'b1;
                           end
                OP_TWRITE: if (cur_open && !cur_full) begin ok = 1'b1; do_push = 1'b1; end
                OP_COMMIT: if (cur_open && !cur_doom) begin ok = 1'b1; do_commit = 1'b1; end
                OP_ABORT:  if (cur_open) begin ok = 1'b1; do_abort = 1'b1; end
                OP_NREAD:  if (!cur_open) begin ok = 1'b1; is_data = 1'b1; end
                OP_NWRITE: if (!cur_open) begin ok = 1'b1; do_nwr = 1'b1; end
                default:   ok = 1'b0;
            endcase
        end
    end

    assign push_ent = '{vld:  1'b1,
                        wr:   (op == OP_TWRITE),
                        addr: req_addr,
                        data: (op == OP_TWRITE) ? req_wdata : mem_rd};

    for (genvar k = 0; k < NCLIENT; k++) begin : g_buf
        logic sel;
        assign sel = (req_cid == CIDW'(k));
        tm_txn_buf u_buf (
            .clk        (clk),
            .rst        (rst),
            .open_i     (do_open && sel),
            .close_i    ((do_commit || do_abort) && sel),
            .push_i     (do_push && sel),
            .push_ent_i (push_ent),
            .doom_set_i (hit_vec[k]),
            .doom_clr_i (do_abort && sel),
            .is_open_o  (open_vec[k]),
            .doomed_o   (doom_vec[k]),
            .full_o     (full_vec[k]),
            .ents_o     (bufs[k])
        );
    end

    assign wmask = do_commit ? write_set(bufs[req_cid]) : addr_mask(req_addr);

    tm_conflict u_conf (
        .en_i    (do_commit || do_nwr),
        .src_i   (req_cid),
        .wmask_i (wmask),
        .open_i  (open_vec),
        .bufs_i  (bufs),
        .hit_o   (hit_vec)
    );

    tm_shared_mem u_mem (
        .clk          (clk),
        .rst          (rst),
        .commit_en_i  (do_commit),
        .commit_buf_i (bufs[req_cid]),
        .nt_en_i      (do_nwr),
        .nt_addr_i    (req_addr),
        .nt_data_i    (req_wdata),
        .rd_addr_i    (req_addr),
        .rd_data_o    (mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_code  <= RSP_IDLE;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            if (!req_valid)   resp_code <= RSP_IDLE;
            else if (!ok)     resp_code <= RSP_ERR;
            else if (is_data) resp_code <= RSP_DATA;
            else              resp_code <= RSP_ACK;
            resp_rdata <= (req_valid && ok && is_data) ? mem_rd : '0;
        end
    end
endmodule

// File: rtl/tm_lazy_ctrl_chk.sv
`timescale 1ns/1ps
module tm_lazy_ctrl_chk
    import tm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [CIDW-1:0]    req_cid,
    input logic [2:0]         req_op,
    input logic               resp_valid,
    input logic [1:0]         resp_code,
    input logic [DW-1:0]      resp_rdata,
    input logic [NCLIENT-1:0] open_vec,
    input logic [NCLIENT-1:0] doom_vec
);
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid && resp_code != 2'd0);  // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid && resp_code == 2'd0);  // R2
    AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        resp_code != 2'd3 |-> resp_rdata == '0);  // R2
    AST_DOUBLE_OPEN: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 3'd0 && open_vec[req_cid] |=> resp_code == 2'd2);  // R3
    AST_DOOMED_COMMIT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 3'd3 && doom_vec[req_cid]
        |=> resp_code == 2'd2 && doom_vec == $past(doom_vec) && open_vec == $past(open_vec));  // R7
    AST_DOOM_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        (doom_vec & ~open_vec) == '0);  // R7
    AST_DIRECT_IN_TXN: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_op == 3'd5 || req_op == 3'd6) && open_vec[req_cid]
        |=> resp_code == 2'd2);  // R8
    AST_RSVD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 3'd7 |=> resp_code == 2'd2 && $stable(open_vec));  // R11
endmodule

bind tm_lazy_ctrl tm_lazy_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_cid    (req_cid),
    .req_op     (req_op),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .resp_rdata (resp_rdata),
    .open_vec   (open_vec),
    .doom_vec   (doom_vec)
);

// File: tb/tm_lazy_ctrl_tb_top.sv
`timescale 1ns/1ps
module tm_lazy_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_cid = '0;
    logic [2:0] req_op = '0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       resp_valid;
    logic [1:0] resp_code;
    logic [7:0] resp_rdata;

    always #2.5 clk = ~clk;

    tm_lazy_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cid(req_cid),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata)
    );

    // behavioural reference model
    int mem [16];
    bit opn [4];
    bit dm  [4];
    int bcnt [4];
    int baddr [4][4];
    int bdat  [4][4];
    bit bwr   [4][4];

    bit    e_v;
    int    e_code;
    int    e_data;
    string e_tag;
    int    nchk;
    int    nfail;

    function automatic bit reads_addr(int k, int a);
        for (int i = 0; i < bcnt[k]; i++)
            if (!bwr[k][i] && baddr[k][i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mem[i] = 0;
        for (int k = 0; k < 4; k++) begin opn[k] = 0; dm[k] = 0; bcnt[k] = 0; end
        e_v = 0; e_code = 0; e_data = 0; e_tag = "R1";
    endtask

    task automatic model_step(bit v, int c, int op, int a, int d);
        e_v = v; e_code = 0; e_data = 0;
        if (!v) return;
        e_code = 2;
        case (op)
            0: if (!opn[c]) begin opn[c] = 1; bcnt[c] = 0; e_code = 1; end
            1: if (opn[c] && bcnt[c] < 4) begin
                   baddr[c][bcnt[c]] = a; bwr[c][bcnt[c]] = 0; bdat[c][bcnt[c]] = mem[a];
                   bcnt[c]++; e_code = 3; e_data = mem[a];
               end
            2: if (opn[c] && bcnt[c] < 4) begin
                   baddr[c][bcnt[c]] = a; bwr[c][bcnt[c]] = 1; bdat[c][bcnt[c]] = d;
                   bcnt[c]++; e_code = 1;
               end
            3: if (opn[c] && !dm[c]) begin
                   for (int i = 0; i < bcnt[c]; i++)
                       if (bwr[c][i]) begin
                           mem[baddr[c][i]] = bdat[c][i];
                           for (int k = 0; k < 4; k++)
                               if (k != c && opn[k] && reads_addr(k, baddr[c][i])) dm[k] = 1;
                       end
                   opn[c] = 0; bcnt[c] = 0; e_code = 1;
               end
            4: if (opn[c]) begin opn[c] = 0; bcnt[c] = 0; dm[c] = 0; e_code = 1; end
            5: if (!opn[c]) begin e_code = 3; e_data = mem[a]; end
            6: if (!opn[c]) begin
                   mem[a] = d;
                   for (int k = 0; k < 4; k++)
                       if (opn[k] && reads_addr(k, a)) dm[k] = 1;
                   e_code = 1;
               end
            default: e_code = 2;
        endcase
    endtask

    task automatic check_now();
        nchk++;
        if (resp_valid !== e_v || resp_code !== 2'(e_code) || resp_rdata !== 8'(e_data)) begin
            nfail++;
            $display("FAIL %s: valid/code/data=%0b/%0d/%0h expected %0b/%0d/%0h",
                     e_tag, resp_valid, resp_code, resp_rdata, e_v, e_code, e_data);
        end
    endtask

    task automatic cyc(bit v, int c, int op, int a, int d, string tag);
        @(negedge clk);
        check_now();
        req_valid = v; req_cid = 2'(c); req_op = 3'(op);
        req_addr = 4'(a); req_wdata = 8'(d);
        model_step(v, c, op, a, d);
        e_tag = tag;
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        nchk = 0; nfail = 0;
        model_reset();
        repeat (3) begin @(negedge clk); check_now(); end  // R1 idle under reset
        @(negedge clk); rst = 1'b0;
        idle("R1");
        idle("R1");
        cyc(1, 0, 5, 3, 0, "R1");          // memory reads zero
        cyc(1, 1, 3, 0, 0, "R1");          // no open transaction
        cyc(1, 0, 0, 0, 0, "R3");          // open ack
        cyc(1, 0, 0, 0, 0, "R3");          // second open err
        cyc(1, 0, 1, 5, 0, "R4");          // read -> 0
        cyc(1, 2, 1, 5, 0, "R4");          // no txn -> err
        cyc(1, 2, 2, 5, 9, "R4");          // write, no txn -> err
        cyc(1, 0, 6, 4, 8'h11, "R8");      // direct write in txn -> err
        cyc(1, 0, 5, 4, 0, "R8");          // direct read in txn -> err
        cyc(1, 0, 2, 6, 8'h55, "R5");      // buffered write
        cyc(1, 1, 0, 0, 0, "R5");
        cyc(1, 1, 1, 6, 0, "R5");          // still old value 0
        cyc(1, 0, 3, 0, 0, "R6");          // commit, dooms client 1
        cyc(1, 2, 5, 6, 0, "R6");          // sees 0x55
        cyc(1, 1, 1, 2, 0, "R12");         // doomed read served
        cyc(1, 1, 2, 7, 8'h21, "R12");     // doomed write ack
        cyc(1, 1, 3, 0, 0, "R7");          // refused
        cyc(1, 1, 0, 0, 0, "R7");          // still open
        cyc(1, 2, 5, 7, 0, "R7");          // refused commit wrote nothing
        cyc(1, 1, 4, 0, 0, "R10");         // abort ack
        cyc(1, 1, 3, 0, 0, "R10");         // no txn -> err
        cyc(1, 1, 4, 0, 0, "R10");         // abort without txn -> err
        cyc(1, 2, 0, 0, 0, "R8");
        cyc(1, 2, 1, 9, 0, "R8");
        cyc(1, 3, 6, 9, 8'h77, "R8");      // direct write dooms client 2
        cyc(1, 3, 5, 9, 0, "R8");          // 0x77 at once
        cyc(1, 2, 3, 0, 0, "R8");          // refused
        cyc(1, 2, 4, 0, 0, "R10");
        cyc(1, 3, 0, 0, 0, "R9");
        cyc(1, 3, 1, 10, 0, "R9");
        cyc(1, 3, 2, 11, 8'hAA, "R9");
        cyc(1, 3, 2, 11, 8'hBB, "R9");     // later entry wins
        cyc(1, 3, 1, 12, 0, "R9");
        cyc(1, 3, 2, 13, 8'hCC, "R9");     // full -> err
        cyc(1, 3, 3, 0, 0, "R9");
        cyc(1, 3, 5, 11, 0, "R6");         // 0xBB
        cyc(1, 3, 5, 13, 0, "R9");         // overflow write not logged
        cyc(1, 0, 0, 0, 0, "R10");
        cyc(1, 0, 2, 14, 8'h33, "R10");
        cyc(1, 0, 4, 0, 0, "R10");
        cyc(1, 0, 5, 14, 0, "R10");        // discarded -> 0
        cyc(1, 0, 7, 0, 0, "R11");
        cyc(1, 0, 5, 14, 0, "R11");
        cyc(1, 1, 0, 0, 0, "R7");
        cyc(1, 1, 1, 1, 0, "R7");
        cyc(1, 2, 0, 0, 0, "R7");
        cyc(1, 2, 2, 2, 8'h44, "R7");
        cyc(1, 2, 3, 0, 0, "R7");          // no overlap, client 1 not doomed
        cyc(1, 1, 3, 0, 0, "R7");          // commit ack
        idle("R2");
        for (int n = 0; n < 600; n++) begin
            cyc(($urandom_range(0, 9) < 8), $urandom_range(0, 3), $urandom_range(0, 7),
                $urandom_range(0, 3), $urandom_range(0, 255), "R2");
        end
        idle("R2");
        idle("R2");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule